// File: doc/BRIEF.md
# Coprocessor State Frame Transfer Sequencer

This block moves a coprocessor's context frame between a 32-bit word-addressed memory port and the coprocessor's register-file port. A frame is a header long word followed by a number of state long words. The header holds a format code in bits 31:24 and an entry count in bits 23:16. Bits 15:0 are reserved. The header always sits at the frame's base address, and entry k sits at base + 4k.

A command supplies a base address and a direction. A save reads the header and entries from the coprocessor and writes them to memory. A restore reads them from memory and writes them into the coprocessor. The header always moves first. A save then walks the entries from the highest address down. A restore walks upward from the base. The count that bounds the walk comes from whichever side the header was read from. `busy` covers the whole command, and a one-cycle `done` marks its end.

Top module: `cpframe_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `cp_we` are all low.
- R2: On either command, the first memory transfer addresses the base address given with the command, and the coprocessor slot selected for it is index 0 (the header).
- R3: On save, the header written to memory keeps bits 31:16 from coprocessor slot 0 and carries zero in bits 15:0.
- R4: On save with count n taken from bits 23:16 of slot 0, the entries follow the header in the order n, n-1, ..., 1. Entry k is written to base + 4k with the data of coprocessor slot k.
- R5: On restore, the transfers run in ascending order 0, 1, ..., n at base + 4k. Every completed read is written to coprocessor slot k (`cp_we` high with `cp_idx` = k and `cp_wdata` equal to the read data). A save produces no coprocessor writes.
- R6: A count of zero gives a header-only transfer of exactly one long word, followed by `done`.
- R7: On restore, the count n is bits 23:16 of the header read from memory, so exactly n + 1 transfers occur.
- R8: While `mem_req` is high and `mem_rdy` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values into the next cycle.
- R9: `busy` is high from the cycle after a command is accepted. It falls in the same cycle that `done` pulses high, which is the cycle after the last transfer completes. `done` lasts one cycle.
- R10: A `cmd_valid` that arrives while `busy` is high is ignored: the running command's direction, addresses and transfer count are unchanged, and no further command follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_save | input | 1 | 1 = save to memory, 0 = restore from memory |
| cmd_ea | input | AW | Frame base address (byte address) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the current long word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_rdy` |
| mem_rdy | input | 1 | Access completes when high with `mem_req` |
| cp_idx | output | 8 | Coprocessor slot: 0 = header, k = entry k |
| cp_rdata | input | 32 | Coprocessor read data for `cp_idx` |
| cp_we | output | 1 | Coprocessor slot write strobe |
| cp_wdata | output | 32 | Coprocessor write data |

## Verification
A wrong slot index or a wrong step direction shows at the very next memory request. It appears as an address that is not base + 4k for the expected k, so the bench compares every request against the expected order as soon as the request rises. A mislatched entry count shows in the second transfer's address on save. On restore it shows as a transfer count that differs from n + 1, seen no later than the cycle `done` is due. Broken hold logic shows as an address or data change during a stall. A command that slips in while busy shows as a changed direction or base on the following request, or as activity after `done`.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
  localparam int unsigned WORDW = 32;
  localparam int unsigned CNTW  = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_XFER
  } cpf_state_e;

  // Entry count carried in a header word.
  function automatic logic [CNTW-1:0] hdr_count(input logic [WORDW-1:0] h);
    return h[23:16];
  endfunction

  // Header as written on save: reserved half cleared.
  function automatic logic [WORDW-1:0] hdr_clean(input logic [WORDW-1:0] h);
    return {h[31:16], 16'h0000};
  endfunction

  // Byte offset of slot k from the frame base.
  function automatic logic [CNTW+1:0] slot_offset(input logic [CNTW-1:0] k);
    return {k, 2'b00};
  endfunction

  // Slot following k: header jumps to n (save) or 1 (restore).
  function automatic logic [CNTW-1:0] slot_next(input logic save,
                                                input logic [CNTW-1:0] k,
                                                input logic [CNTW-1:0] n);
    if (k == '0) return save ? n : CNTW'(1);
    return save ? k - CNTW'(1) : k + CNTW'(1);
  endfunction

  // True when slot k is the final transfer of the frame.
  function automatic logic slot_last(input logic save,
                                     input logic [CNTW-1:0] k,
                                     input logic [CNTW-1:0] n);
    if (k == '0) return n == '0;
    return save ? (k == CNTW'(1)) : (k == n);
  endfunction
endpackage

// File: rtl/cpf_ctrl.sv
module cpf_ctrl
  import cpf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic            cmd_save,
  input  logic            xfer_fire,
  input  logic [CNTW-1:0] hdr_n,
  output cpf_state_e      state,
  output logic            mode_save,
  output logic [CNTW-1:0] slot,
  output logic            accept,
  output logic            busy,
  output logic            done
);
  logic [CNTW-1:0] n_q;
  logic [CNTW-1:0] n_eff;
  logic            is_last;

  assign accept  = (state == ST_IDLE) && cmd_valid;
  assign busy    = (state != ST_IDLE);
  assign n_eff   = (slot == '0) ? hdr_n : n_q;
  assign is_last = slot_last(mode_save, slot, n_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      mode_save <= 1'b0;
      slot      <= '0;
      n_q       <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (cmd_valid) begin
          mode_save <= cmd_save;
          slot      <= '0;
          state     <= ST_LOAD;
        end
        ST_LOAD: state <= ST_XFER;
        ST_XFER: if (xfer_fire) begin
          if (slot == '0) n_q <= hdr_n;
          if (is_last) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            slot  <= slot_next(mode_save, slot, n_eff);
            state <= ST_LOAD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_busy_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r10_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> $stable(mode_save));
  a_r6_zero_count_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_fire && slot == '0 && hdr_n == '0) |=> (done && !busy));
endmodule

// File: rtl/cpf_datapath.sv
module cpf_datapath
  import cpf_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [AW-1:0]    cmd_ea,
  input  logic             load,
  input  logic             mode_save,
  input  logic [CNTW-1:0]  slot,
  input  logic [WORDW-1:0] cp_rdata,
  input  logic [WORDW-1:0] mem_rdata,
  input  logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic [WORDW-1:0] mem_wdata,
  output logic [CNTW-1:0]  hdr_n
);
  logic [AW-1:0]    base_q;
  logic [WORDW-1:0] wbuf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      wbuf_q <= '0;
    end else begin
      if (accept) base_q <= cmd_ea;
      if (load && mode_save)
        wbuf_q <= (slot == '0) ? hdr_clean(cp_rdata) : cp_rdata;
    end
  end

  assign mem_addr  = base_q + AW'(slot_offset(slot));
  assign mem_wdata = wbuf_q;
  assign hdr_n     = mode_save ? hdr_count(wbuf_q) : hdr_count(mem_rdata);

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mode_save && slot == '0) |-> (mem_wdata[15:0] == 16'h0000));
  a_r2_header_at_base: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && slot == '0) |-> (mem_addr == base_q));
endmodule

// File: rtl/cpframe_seq.sv
module cpframe_seq
  import cpf_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_save,
  input  logic [AW-1:0]    cmd_ea,
  output logic             busy,
  output logic             done,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [WORDW-1:0] mem_wdata,
  input  logic [WORDW-1:0] mem_rdata,
  input  logic             mem_rdy,
  output logic [CNTW-1:0]  cp_idx,
  input  logic [WORDW-1:0] cp_rdata,
  output logic             cp_we,
  output logic [WORDW-1:0] cp_wdata
);
  cpf_state_e      state;
  logic            mode_save;
  logic [CNTW-1:0] slot;
  logic            accept;
  logic            xfer_fire;
  logic [CNTW-1:0] hdr_n;

  assign mem_req   = (state == ST_XFER);
  assign mem_we    = mode_save;
  assign xfer_fire = mem_req && mem_rdy;
  assign cp_idx    = slot;
  assign cp_we     = xfer_fire && !mode_save;
  assign cp_wdata  = mem_rdata;

  cpf_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_save  (cmd_save),
    .xfer_fire (xfer_fire),
    .hdr_n     (hdr_n),
    .state     (state),
    .mode_save (mode_save),
    .slot      (slot),
    .accept    (accept),
    .busy      (busy),
    .done      (done)
  );

  cpf_datapath #(.AW(AW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .cmd_ea    (cmd_ea),
    .load      (state == ST_LOAD),
    .mode_save (mode_save),
    .slot      (slot),
    .cp_rdata  (cp_rdata),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .hdr_n     (hdr_n)
  );

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));
  a_r5_cp_write_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    cp_we |-> (mem_req && !mem_we && mem_rdy));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !cp_we));
endmodule

// File: tb/cpframe_seq_tb.sv
module cpframe_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_save = 1'b0;
  logic [31:0] cmd_ea = '0;
  logic        busy, done, mem_req, mem_we, cp_we;
  logic [31:0] mem_addr, mem_wdata, cp_wdata, cp_rdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_rdy = 1'b0;
  logic [7:0]  cp_idx;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] mem [0:1023];
  logic [31:0] cp_salt = 32'h1;
  logic [7:0]  cp_n = 8'd0;
  logic [7:0]  log_idx [0:1023];
  logic [31:0] log_dat [0:1023];
  int          n_log = 0;

  always #5 clk = ~clk;

  cpframe_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_save(cmd_save),
    .cmd_ea(cmd_ea), .busy(busy), .done(done), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .cp_idx(cp_idx),
    .cp_rdata(cp_rdata), .cp_we(cp_we), .cp_wdata(cp_wdata)
  );

  // Coprocessor model: slot 0 is a header with count cp_n.
  function automatic logic [31:0] cp_val(input logic [7:0] k,
                                         input logic [31:0] salt,
                                         input logic [7:0] n);
    if (k == 8'd0) return {8'hA0 ^ salt[7:0], n, salt[31:16]};
    return (salt * {24'd0, k}) ^ 32'h5A3C_0F96 ^ {4'd0, k, 20'd0};
  endfunction

  always_comb cp_rdata = cp_val(cp_idx, cp_salt, cp_n);

  always @(posedge clk) begin
    if (cp_we) begin
      log_idx[n_log % 1024] <= cp_idx;
      log_dat[n_log % 1024] <= cp_wdata;
      n_log <= n_log + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Runs one command; eaw is the base as a word index.
  task automatic run_cmd(input bit save, input int eaw, input bit spurious);
    int   n, t, cyc, start;
    bit   pending, fin;
    logic [7:0]  seq [0:255];
    logic [31:0] pa, pd, ea, exp_a, exp_d;
    ea = 32'(eaw) << 2;
    n  = save ? int'(cp_n) : int'(mem[eaw][23:16]);
    // Expected slot order: header, then descending (save) or ascending (restore).
    seq[0] = 8'd0;
    for (int j = 1; j <= n; j++) seq[j] = save ? 8'(n + 1 - j) : 8'(j);
    start = n_log;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_save = save; cmd_ea = ea;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy === 1'b1, "R9", "busy after accept", {31'd0, busy}, 32'd1);
    t = 0; cyc = 0; pending = 0; fin = 0; pa = '0; pd = '0;
    while (1) begin
      mem_rdy   = 1'b0;
      cmd_valid = 1'b0;
      if (fin) begin
        check(done === 1'b1 && busy === 1'b0, "R9", "done/busy at end",
              {30'd0, done, busy}, 32'd2);
        break;
      end
      if (spurious && cyc == 3) begin
        cmd_valid = 1'b1; cmd_save = !save; cmd_ea = 32'h0000_0F00;
      end
      if (mem_req) begin
        if (!pending) begin
          exp_a = ea + {22'd0, seq[t], 2'b00};
          check(mem_addr === exp_a, t == 0 ? "R2" : (save ? "R4" : "R5"),
                "address", mem_addr, exp_a);
          check(mem_we === save, "R10", "direction", {31'd0, mem_we}, {31'd0, save});
          if (save) begin
            exp_d = (t == 0) ? {cp_val(8'd0, cp_salt, cp_n)[31:16], 16'h0}
                             : cp_val(seq[t], cp_salt, cp_n);
            check(mem_wdata === exp_d, t == 0 ? "R3" : "R4", "write data",
                  mem_wdata, exp_d);
          end
          pending = 1; pa = mem_addr; pd = mem_wdata;
        end else begin
          check(mem_addr === pa && mem_wdata === pd, "R8", "hold on stall",
                mem_addr, pa);
        end
        if ($urandom % 3 != 0) begin
          mem_rdy = 1'b1;
          if (save) mem[mem_addr[11:2]] = mem_wdata;
          else mem_rdata = mem[mem_addr[11:2]];
          pending = 0;
          t++;
          if (t == n + 1) fin = 1;
        end
      end else if (!fin && t > n) begin
        check(1'b0, "R7", "extra transfer", 32'(t), 32'(n + 1));
      end
      cyc++;
      if (cyc > 5000) begin
        check(1'b0, "R9", "command never finished", 32'(t), 32'(n + 1));
        break;
      end
      @(negedge clk);
    end
    mem_rdy = 1'b0;
    check(t == n + 1, n == 0 ? "R6" : "R7", "transfer count", 32'(t), 32'(n + 1));
    if (save) begin
      check(n_log == start, "R5", "no cp writes on save", 32'(n_log - start), 32'd0);
    end else begin
      check(n_log - start == n + 1, "R5", "cp write count", 32'(n_log - start), 32'(n + 1));
      for (int j = 0; j <= n && j < n_log - start; j++) begin
        check(log_idx[(start + j) % 1024] === 8'(j), "R5", "cp slot order",
              {24'd0, log_idx[(start + j) % 1024]}, 32'(j));
        check(log_dat[(start + j) % 1024] === mem[eaw + j], "R5", "cp data",
              log_dat[(start + j) % 1024], mem[eaw + j]);
      end
    end
    if (spurious) begin
      repeat (3) @(negedge clk);
      check(busy === 1'b0 && mem_req === 1'b0, "R10", "ignored command started",
            {30'd0, busy, mem_req}, 32'd0);
    end
  endtask

  initial begin
    void'($urandom(32'h00C0_FFEE));
    for (int i = 0; i < 1024; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0 && cp_we === 1'b0,
          "R1", "reset outputs", {28'd0, busy, done, mem_req, cp_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && mem_req === 1'b0, "R1", "idle after reset",
          {30'd0, busy, mem_req}, 32'd0);

    // Directed corners.
    cp_salt = 32'h1357_9BDF; cp_n = 8'd0;
    run_cmd(1'b1, 16, 1'b0);                       // R6 save header only
    mem[40] = {8'h11, 8'd0, 16'hBEEF};
    run_cmd(1'b0, 40, 1'b0);                       // R6 restore header only
    cp_n = 8'd1;
    run_cmd(1'b1, 100, 1'b0);                      // R4 single entry
    cp_n = 8'd6; cp_salt = 32'hDEAD_0001;
    run_cmd(1'b1, 200, 1'b1);                      // R10 during save
    run_cmd(1'b0, 200, 1'b1);                      // R7 restore of saved frame
    mem[300][23:16] = 8'd255;
    run_cmd(1'b0, 300, 1'b0);                      // R7 largest count
    cp_n = 8'd255;
    run_cmd(1'b1, 600, 1'b0);                      // R4 largest count

    // Random mix.
    for (int r = 0; r < 24; r++) begin
      int eaw;
      eaw = int'($urandom % 700);
      if (r % 2 == 0) begin
        cp_salt = $urandom;
        cp_n    = 8'($urandom % 40);
        run_cmd(1'b1, eaw, r % 3 == 0);
      end else begin
        mem[eaw][23:16] = 8'($urandom % 40);
        run_cmd(1'b0, eaw, r % 3 == 0);
      end
    end

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule